// File: doc/BRIEF.md
# Sample-Rate Control Register with Sleep Override

This block holds an 8-bit system control byte and uses it to pace sampling. Software writes and reads the byte through a plain address/data port. While the byte's run bit is set, a divider counts an external 800 Hz base tick and emits a one-cycle sample strobe once per programmed period. The period normally comes from a three-bit data-rate code. While the external sleep input is high, a two-bit sleep-rate code selects the period instead.

Each configuration field is locked while sampling runs. A write that arrives while the run bit is set can change only the run bit. Clearing the run bit returns the block to standby: the divider stops and its counter is held at zero. Restarting sampling, entering sleep or leaving sleep restarts the divider, so the next strobe comes one full new period later. The control byte also drives two plain mode flags, low-noise and fast-read, for use by neighbouring logic.

Top module: `sample_rate_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, no strobe is produced and both mode flags are low.
- R2: A read at the control address returns the current control byte in both standby and run mode, and a read at any other address returns 0x00. The byte layout is bit 0 run, bit 1 fast-read, bit 2 low-noise, bits 5:3 data-rate code and bits 7:6 sleep-rate code.
- R3: While the run bit is 0, a write to the control address loads all eight bits.
- R4: While the run bit is 1, a write to the control address updates only bit 0, and bits 7:1 keep their values.
- R5: With the run bit at 1 and sleep low, a strobe follows every N-th base tick. The data-rate codes 0 to 7 give N = 1, 2, 4, 8, 16, 64, 128 and 512.
- R6: With the run bit at 1 and sleep high, N comes from the sleep-rate code instead. The sleep-rate codes 0 to 3 give N = 16, 64, 128 and 512.
- R7: In standby no strobe is produced, whatever the tick and sleep inputs do, and the tick count is held at zero.
- R8: A change of the sleep input while running, or the clock cycle after the run bit rises, discards that cycle's tick. Counting restarts from zero, so the first strobe follows the N-th tick after that cycle.
- R9: A strobe is high for one clock cycle, the cycle after the clock edge that samples the completing tick.
- R10: A write to any address other than the control address leaves the control byte unchanged.
- R11: The low-noise output equals bit 2 and the fast-read output equals bit 1 of the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable for the register port |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on addr_i |
| tick_i | input | 1 | 800 Hz base tick, one cycle wide |
| sleep_i | input | 1 | Sleep mode request, selects the sleep-rate code |
| strobe_o | output | 1 | One-cycle sample strobe |
| low_noise_o | output | 1 | Low-noise mode flag |
| fast_read_o | output | 1 | Fast-read mode flag |

## Verification
The bench builds the block with its default parameters: a 4-bit address, the control byte at 0xA and a largest divisor of 512. Because the bench drives the base tick itself, every cycle or every second or third cycle, even the 512-tick period takes only about a thousand clocks. This keeps all eight data rates and all four sleep rates within the cycle budget, each for at least two full periods. The reference model follows each sleep toggle, each locked write and each standby interval cycle by cycle, and short sleep pulses exercise divider restarts that happen in the middle of a period.

// File: rtl/srate_pkg.sv
package srate_pkg;
  localparam int unsigned MAX_DIV = 512;
  localparam int unsigned DIV_W   = $clog2(MAX_DIV) + 1;

  typedef struct packed {
    logic [1:0] slp_rate;
    logic [2:0] data_rate;
    logic       low_noise;
    logic       fast_read;
    logic       run;
  } ctrl_t;

  function automatic logic [DIV_W-1:0] data_div(input logic [2:0] code);
    case (code)
      3'd0: data_div = DIV_W'(1);
      3'd1: data_div = DIV_W'(2);
      3'd2: data_div = DIV_W'(4);
      3'd3: data_div = DIV_W'(8);
      3'd4: data_div = DIV_W'(16);
      3'd5: data_div = DIV_W'(64);
      3'd6: data_div = DIV_W'(128);
      default: data_div = DIV_W'(512);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] sleep_div(input logic [1:0] code);
    case (code)
      2'd0: sleep_div = DIV_W'(16);
      2'd1: sleep_div = DIV_W'(64);
      2'd2: sleep_div = DIV_W'(128);
      default: sleep_div = DIV_W'(512);
    endcase
  endfunction
endpackage

// File: rtl/srate_regs.sv
module srate_regs
  import srate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      cfg_o
);
  ctrl_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      if (cfg_q.run) cfg_q.run <= wdata_i[0];  // fields locked while running
      else           cfg_q     <= ctrl_t'(wdata_i);
    end
  end

  assign cfg_o = cfg_q;

  AST_LOCKED_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.run |=> $stable(cfg_q[7:1])) else $error("fields changed while running"); // R4
endmodule

// File: rtl/srate_sel.sv
module srate_sel
  import srate_pkg::*;
(
  input  ctrl_t            cfg_i,
  input  logic             sleep_i,
  output logic [DIV_W-1:0] div_o
);
  always_comb begin
    if (sleep_i) div_o = sleep_div(cfg_i.slp_rate);
    else         div_o = data_div(cfg_i.data_rate);
  end
endmodule

// File: rtl/srate_div.sv
module srate_div #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             sleep_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             strobe_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             run_q, sleep_q, strobe_q;
  logic             restart, last, fire;

  assign restart = run_i && (!run_q || (sleep_i != sleep_q));
  assign last    = (cnt_q == div_i - DIV_W'(1));
  assign fire    = run_i && !restart && tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      run_q    <= 1'b0;
      sleep_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      run_q    <= run_i;
      sleep_q  <= sleep_i;
      strobe_q <= fire;
      if (!run_i || restart) cnt_q <= '0;
      else if (tick_i)       cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
    end
  end

  assign strobe_o = strobe_q;

  AST_CNT_BELOW_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !restart) |-> (cnt_q < div_i)) else $error("count beyond divisor"); // R5
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !strobe_q) else $error("strobe in standby"); // R7
  AST_STANDBY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)) else $error("count moved in standby"); // R7
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (cnt_q == '0)) else $error("restart did not clear"); // R8
  AST_STROBE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> $past(tick_i)) else $error("strobe without tick"); // R9
endmodule

// File: rtl/sample_rate_ctrl.sv
module sample_rate_ctrl
  import srate_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('hA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  input  logic              sleep_i,
  output logic              strobe_o,
  output logic              low_noise_o,
  output logic              fast_read_o
);
  ctrl_t            cfg;
  logic [DIV_W-1:0] div;
  logic             hit;

  assign hit = (addr_i == CTRL_ADDR);

  srate_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && hit),
    .wdata_i (wdata_i),
    .cfg_o   (cfg)
  );

  srate_sel u_sel (
    .cfg_i   (cfg),
    .sleep_i (sleep_i),
    .div_o   (div)
  );

  srate_div #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (cfg.run),
    .sleep_i  (sleep_i),
    .tick_i   (tick_i),
    .div_i    (div),
    .strobe_o (strobe_o)
  );

  assign rdata_o     = hit ? cfg : 8'h00;
  assign low_noise_o = cfg.low_noise;
  assign fast_read_o = cfg.fast_read;

  AST_FOREIGN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> $stable(cfg)) else $error("foreign write changed byte"); // R10
endmodule

// File: tb/tb_sample_rate_ctrl.sv
module tb_sample_rate_ctrl;
  localparam logic [3:0] CA = 4'hA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       we = 1'b0;
  logic [3:0] addr = CA;
  logic [7:0] wdata = 8'h00;
  logic       tick = 1'b0;
  logic       sleep = 1'b0;
  logic [7:0] rdata;
  logic       strobe, lnoise, fread;

  sample_rate_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .sleep_i(sleep), .strobe_o(strobe),
    .low_noise_o(lnoise), .fast_read_o(fread)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  int    gap = 1, gctr = 0;
  bit    done = 1'b0;

  // reference model state
  logic [7:0] m_reg = 8'h00;
  int         m_cnt = 0, m_div = 1;
  bit         m_prun = 0, m_psleep = 0, m_strobe = 0, m_run = 0, m_rst = 0;

  function automatic int ddiv(input int c);
    int t[8] = '{1, 2, 4, 8, 16, 64, 128, 512};
    return t[c];
  endfunction
  function automatic int sdiv(input int c);
    int t[4] = '{16, 64, 128, 512};
    return t[c];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 8'h00; m_cnt = 0; m_prun = 0; m_psleep = 0; m_strobe = 0;
    end else begin
      m_run    = m_reg[0];
      m_div    = sleep ? sdiv(int'(m_reg[7:6])) : ddiv(int'(m_reg[5:3]));
      m_rst    = m_run && (!m_prun || sleep != m_psleep);
      m_strobe = m_run && !m_rst && tick && (m_cnt == m_div - 1);
      if (!m_run || m_rst) m_cnt = 0;
      else if (tick) m_cnt = (m_cnt == m_div - 1) ? 0 : m_cnt + 1;
      m_prun   = m_run;
      m_psleep = sleep;
      if (we && addr == CA) m_reg = m_reg[0] ? {m_reg[7:1], wdata[0]} : wdata;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("strobe", int'(strobe), int'(m_strobe));
      chk("rdata", int'(rdata), (addr == CA) ? int'(m_reg) : 0);
      chk("low_noise", int'(lnoise), int'(m_reg[2]));
      chk("fast_read", int'(fread), int'(m_reg[1]));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
    tick = (gctr == 0);
    gctr = (gctr + 1) % gap;
  endtask
  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc();
    we = 1'b0; addr = CA;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    cur_req = "R1";
    run(4);

    cur_req = "R3 R11";
    wr(CA, 8'h06); run(3);
    wr(CA, 8'h02); run(3);
    wr(CA, 8'h00); run(2);

    cur_req = "R2 R10";
    wr(4'h3, 8'hFF); run(2);
    wr(4'h0, 8'h01); run(2);
    addr = 4'h5; run(3); addr = CA;
    wr(CA, 8'hC5); addr = 4'hB; run(3); addr = CA; run(2);
    wr(CA, 8'hC4); wr(4'h2, 8'h00); run(2);
    wr(CA, 8'h00);

    gap = 2; gctr = 0;
    for (int r = 0; r < 8; r++) begin
      cur_req = "R5 R9";
      wr(CA, {2'b00, 3'(r), 3'b000});
      wr(CA, {2'b00, 3'(r), 3'b001});
      run(4 * ddiv(r) + 20);
      cur_req = "R4";
      wr(CA, 8'hFE ^ {2'b00, 3'(r), 3'b000});
      run(3);
      wr(CA, 8'hFF); run(3);
      wr(CA, 8'h00); run(2);
    end

    cur_req = "R7";
    gap = 1; gctr = 0;
    wr(CA, 8'h00);
    for (int i = 0; i < 10; i++) begin sleep = ~sleep; run(7); end
    sleep = 1'b0;
    wr(CA, 8'h10); run(40);
    cur_req = "R7 R8";
    wr(CA, 8'h11); run(40);
    wr(CA, 8'h10); run(5);
    wr(CA, 8'h11); run(40);
    wr(CA, 8'h00);

    for (int s = 0; s < 4; s++) begin
      cur_req = "R6 R8";
      wr(CA, {2'(s), 3'd1, 3'b000});
      wr(CA, {2'(s), 3'd1, 3'b001});
      run(11);
      sleep = 1'b1; run(2 * sdiv(s) + 20);
      sleep = 1'b0; run(13);
      sleep = 1'b1; run(5);
      sleep = 1'b0; run(5);
      sleep = 1'b1; run(sdiv(s) + 3);
      sleep = 1'b0; run(9);
      wr(CA, 8'h00); run(2);
    end

    cur_req = "R5 R9";
    gap = 3; gctr = 0;
    wr(CA, 8'h20); wr(CA, 8'h21); run(3 * 16 * 3 + 10);
    wr(CA, 8'h00); run(3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule